// File: doc/BRIEF.md
# Scalar/Vector Issue Hazard Gate

The gate sits in front of a single issue port that serves both scalar and vector instructions from one wave. Each cycle the front end presents at most one instruction as a 3-bit class code together with a valid bit. The gate decides whether that instruction may leave this cycle or must be held back, and it drives `stall_o` and `ready_o` to say which. An instruction is issued in a cycle where `valid_i` and `ready_o` are both high. While it is stalled, the front end keeps the same instruction presented.

Two kinds of delay are enforced, and both are fixed delays between execution units. The first covers forwarding from the vector unit to the scalar unit. After a vector integer add/subtract or a lane-read issues, a scalar ALU instruction may not issue until a fixed window of cycles has passed. The second covers the condition flags. A conditional branch that directly follows a writer of the flag it tests pays a fixed penalty in stalled cycles. A resident-wave count input turns off every stall once enough waves are resident to hide the latencies. No register indices are compared.

Top module: `issue_hazard_gate`

## Requirements
- R1: After reset is released, the first presented instruction of any class issues in the cycle it is first presented, with `stall_o` low.
- R2: Issue of a vector integer add/sub (class 1) starts a window of FWD_DELAY (default 16) cycles. A scalar ALU instruction (class 3) presented k cycles after that issue (1 <= k < 16) stalls, and it issues in the cycle exactly 16 cycles after the producer.
- R3: A lane-read instruction (class 2) opens the same 16-cycle window as class 1.
- R4: A newer producer of class 1 or 2 issued inside an open window restarts the window from its own issue cycle.
- R5: Only class 3 waits for the forwarding window. Classes 0, 1, 2, 4 and 5 issue at once while the window is open, and the window keeps running meanwhile.
- R6: A branch on VCCZ/EXECZ (class 6) whose preceding issued instruction was a VCC/EXEC writer (class 4) stalls for exactly PENALTY (default 4) cycles. This holds even when idle cycles with `valid_i` low separate the two.
- R7: A branch on SCC (class 7) stalls for exactly 4 cycles when its preceding issued instruction was an SCC writer (class 5) or a VCC/EXEC writer (class 4).
- R8: A flag hazard exists only for the instruction issued directly after the writer. Any issued instruction of another class clears it. An SCC writer (class 5) does not delay a class 6 branch.
- R9: When `waves_i` exceeds 4*NUM_CU (default 8), `stall_o` is never asserted. When `waves_i` equals 4*NUM_CU, stalls apply normally.
- R10: `ready_o` equals `valid_i` and not `stall_o`. `stall_o` is low whenever `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | An instruction is presented |
| class_i | input | 3 | Class: 0 other, 1 vector int add/sub, 2 lane read, 3 scalar ALU, 4 VCC/EXEC writer, 5 SCC writer, 6 branch on VCCZ/EXECZ, 7 branch on SCC |
| waves_i | input | WAVE_W (6) | Number of resident waves |
| stall_o | output | 1 | Presented instruction is held this cycle |
| ready_o | output | 1 | Presented instruction issues this cycle |

## Verification
Several properties are checked every cycle by the assertions:
- the forwarding counter reloads on every producer issue and then counts down by one per cycle;
- a scalar ALU instruction directly behind a producer is held;
- a flag branch directly behind its writer is held;
- the penalty counter never passes its limit;
- the flags clear after a non-writer issues.

The exact stall lengths can only be shown by the bench's timed scenarios. These cover a window shortened by idle gaps, a window restarted by a second producer, and the masking threshold at exactly 4*NUM_CU and one wave above it.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_VIADD  = 3'd1,
    CLS_LANERD = 3'd2,
    CLS_SALU   = 3'd3,
    CLS_WR_VE  = 3'd4,
    CLS_WR_SCC = 3'd5,
    CLS_BR_VE  = 3'd6,
    CLS_BR_SCC = 3'd7
  } cls_e;
endpackage

// File: rtl/hz_fwd_timer.sv
module hz_fwd_timer #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY - 1);

  logic [CNT_W-1:0] cnt_q;

  // window counts the producer's own issue cycle, hence DELAY-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_TIMER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == RELOAD); // R4
  AST_TIMER_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2
endmodule

// File: rtl/hz_flag_track.sv
module hz_flag_track
  import hz_pkg::*;
#(
  parameter int unsigned PENALTY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic issue_i,
  input  cls_e cls_i,
  output logic hazard_o
);
  localparam int unsigned PEN_W = $clog2(PENALTY + 1);
  localparam logic [PEN_W-1:0] PEN_MAX = PEN_W'(PENALTY);

  logic             ve_q, scc_q;
  logic [PEN_W-1:0] pen_q;
  logic             raw_hz;

  assign raw_hz = (cls_i == CLS_BR_VE  && ve_q) ||
                  (cls_i == CLS_BR_SCC && scc_q);
  assign hazard_o = raw_hz && (pen_q != PEN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ve_q  <= 1'b0;
      scc_q <= 1'b0;
      pen_q <= '0;
    end else if (issue_i) begin
      ve_q  <= (cls_i == CLS_WR_VE);
      // a VCC/EXEC write also disturbs SCC
      scc_q <= (cls_i == CLS_WR_SCC) || (cls_i == CLS_WR_VE);
      pen_q <= '0;
    end else if (valid_i && hazard_o) begin
      pen_q <= pen_q + 1'b1;
    end
  end

  AST_PEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_q <= PEN_MAX); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && cls_i != CLS_WR_VE && cls_i != CLS_WR_SCC) |=> (!ve_q && !scc_q)); // R8
endmodule

// File: rtl/issue_hazard_gate.sv
module issue_hazard_gate
  import hz_pkg::*;
#(
  parameter int unsigned WAVE_W    = 6,
  parameter int unsigned NUM_CU    = 2,
  parameter int unsigned FWD_DELAY = 16,
  parameter int unsigned PENALTY   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        class_i,
  input  logic [WAVE_W-1:0] waves_i,
  output logic              stall_o,
  output logic              ready_o
);
  localparam int unsigned MASK_LIMIT = 4 * NUM_CU;

  cls_e cls;
  logic masked, issue, fwd_busy, flag_hz, prod;

  assign cls    = cls_e'(class_i);
  assign masked = 32'(waves_i) > MASK_LIMIT;
  assign prod   = (cls == CLS_VIADD) || (cls == CLS_LANERD);

  hz_fwd_timer #(.DELAY(FWD_DELAY)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue && prod),
    .busy_o (fwd_busy)
  );

  hz_flag_track #(.PENALTY(PENALTY)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .issue_i  (issue),
    .cls_i    (cls),
    .hazard_o (flag_hz)
  );

  assign stall_o = valid_i && !masked && ((cls == CLS_SALU && fwd_busy) || flag_hz);
  assign ready_o = valid_i && !stall_o;
  assign issue   = ready_o;

  AST_SALU_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && prod) |=> ((valid_i && cls == CLS_SALU &&
                            32'(waves_i) <= MASK_LIMIT) -> stall_o)); // R2
  AST_BRANCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cls == CLS_WR_VE) |=> ((valid_i && class_i[2:1] == 2'b11 &&
                                        32'(waves_i) <= MASK_LIMIT) -> stall_o)); // R7
  AST_IDLE_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!stall_o && !ready_o)); // R10
endmodule

// File: tb/sim_issue_hazard_gate.sv
module sim_issue_hazard_gate;
  localparam int WAVE_W = 6;
  localparam int NUM_CU = 2;
  localparam int LIMIT  = 4 * NUM_CU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [2:0] cls = 3'd0;
  logic [WAVE_W-1:0] waves = WAVE_W'(1);
  logic stall, ready;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct { int exp; string tag; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk; // 125 MHz

  issue_hazard_gate #(.WAVE_W(WAVE_W), .NUM_CU(NUM_CU)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .class_i(cls),
    .waves_i(waves), .stall_o(stall), .ready_o(ready)
  );

  // monitor: counts stalled cycles per instruction, compares on issue
  int waited = 0;
  always @(negedge clk) begin
    if (rst_n && valid) begin
      total++;
      if (ready !== !stall) begin
        bad++;
        $display("FAIL R10 ready=%0b expected=%0b", ready, !stall);
      end
      if (stall) waited++;
      if (ready) begin
        item_t it;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R10 unexpected issue actual=1 expected=0");
        end else begin
          it = exp_q.pop_front();
          if (waited != it.exp) begin
            bad++;
            $display("FAIL %s stall=%0d expected=%0d", it.tag, waited, it.exp);
          end
        end
        waited = 0;
      end
    end
  end

  task automatic send(input logic [2:0] c, input int exp, input string tag);
    bit acc;
    exp_q.push_back('{exp, tag});
    valid = 1'b1;
    cls = c;
    do begin
      @(negedge clk);
      acc = ready;
      @(posedge clk);
      #1;
    end while (!acc);
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check_idle();
    @(negedge clk);
    total++;
    if (stall !== 1'b0 || ready !== 1'b0) begin
      bad++;
      $display("FAIL R10 idle stall=%0b ready=%0b expected=0 0", stall, ready);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check_idle();                 // R10 / R1 reset state
    @(posedge clk); #1;
    send(3'd3, 0, "R1");          // salu after reset
    send(3'd6, 0, "R1");          // branch after reset
    // R2 window, back to back
    send(3'd1, 0, "R5");
    send(3'd3, 15, "R2");
    // R2 shortened by idle gap
    send(3'd1, 0, "R5");
    idle(5);
    send(3'd3, 10, "R2");
    // R2 expired window
    send(3'd1, 0, "R5");
    idle(20);
    send(3'd3, 0, "R2");
    // R3 lane read
    send(3'd2, 0, "R5");
    send(3'd3, 15, "R3");
    // R4 restart
    send(3'd1, 0, "R5");
    idle(4);
    send(3'd2, 0, "R4");
    send(3'd3, 15, "R4");
    // R5 other class inside window, window keeps running
    send(3'd1, 0, "R5");
    send(3'd0, 0, "R5");
    send(3'd5, 0, "R5");
    send(3'd3, 13, "R5");
    // R6
    send(3'd4, 0, "R6");
    send(3'd6, 4, "R6");
    send(3'd4, 0, "R6");
    idle(3);
    send(3'd6, 4, "R6");
    // R7
    send(3'd5, 0, "R7");
    send(3'd7, 4, "R7");
    send(3'd4, 0, "R7");
    send(3'd7, 4, "R7");
    // R8
    send(3'd4, 0, "R8");
    send(3'd0, 0, "R8");
    send(3'd6, 0, "R8");
    send(3'd5, 0, "R8");
    send(3'd6, 0, "R8");
    // R9 at limit: stalls apply
    waves = WAVE_W'(LIMIT);
    send(3'd1, 0, "R9");
    send(3'd3, 15, "R9");
    // R9 above limit: masked
    waves = WAVE_W'(LIMIT + 1);
    send(3'd1, 0, "R9");
    send(3'd3, 0, "R9");
    send(3'd4, 0, "R9");
    send(3'd6, 0, "R9");
    send(3'd5, 0, "R9");
    send(3'd7, 0, "R9");
    check_idle();
    idle(2);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R10 pending=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule